// File: doc/BRIEF.md
# Nine-Bit Command/Data Serial Writer

This block is a write-only serial master for display controllers that take 9-bit words. The leading bit of each word marks it as a command or a parameter, and the remaining eight bits carry a register byte or a parameter byte. A host hands over one transaction at a time: a register byte, a parameter count and a 16-bit parameter value. The block then sends the command word and zero, one or two parameter words while the chip select is held low for the whole transaction.

The request port is a valid/ready stream. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. While a transfer is in progress, `req_ready` stays low. A host that keeps `req_valid` high with its fields stable simply waits, and its request is taken as soon as the link is free. `done` pulses once per finished transaction, and `busy` reports that a transaction is running. The serial clock idles high. Each half period of the serial clock lasts `HALF_DIV` system clocks.

Top module: `spi9_writer`

## Requirements
- R1: Every serial word is 9 bits long and is shifted out MSB first. Its first bit is 0 for the command word and 1 for each parameter word, and the next eight bits are the byte, MSB first. A frame holds 9 × (words) bits.
- R2: With `req_cnt` = 0, the frame is the command word `{0, req_reg}` alone (9 bits).
- R3: With `req_cnt` = 1, the frame is the command word followed by one parameter word `{1, req_param[7:0]}` (18 bits).
- R4: With `req_cnt` = 2, the frame is the command word, then `{1, req_param[15:8]}`, then `{1, req_param[7:0]}` (27 bits).
- R5: A `req_cnt` of 3 produces exactly the frame of `req_cnt` = 2.
- R6: The link uses clock polarity high and sampling on the rising edge. `sclk` is high whenever `cs_n` is high, `mosi` changes only together with a falling `sclk` edge, and `mosi` is stable at every rising `sclk` edge.
- R7: `cs_n` falls at least `HALF_DIV` clocks before the first falling `sclk` edge. It rises at least `HALF_DIV` clocks after the last rising edge. It stays low across all words of the transaction.
- R8: `req_ready` is low and `busy` is high from acceptance until `cs_n` returns high. A request held valid during that time is accepted afterwards and sent intact.
- R9: `done` is high for exactly one clock, in the cycle where `cs_n` returns high, once per transaction.
- R10: After reset, `cs_n` = 1, `sclk` = 1, `req_ready` = 1, `busy` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_reg | input | 8 | Register (command) byte |
| req_cnt | input | 2 | Parameter word count: 0, 1, 2 (3 acts as 2) |
| req_param | input | 16 | Parameter value |
| done | output | 1 | One-clock pulse at transaction end |
| busy | output | 1 | Transaction in progress |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench sends each parameter count, including the count of 3 that must fold onto 2. A design that mishandled this would send a fourth word or a truncated frame. It decodes the captured bit stream, which catches a swapped byte order, a lost command/data flag bit or a wrong frame length. It measures the time between chip select and the clock edges, so a select that moved together with the first or last clock edge would fail. A second request is held valid during a transfer. A design that took it early, dropped it, or pulsed `done` more than once would show a corrupted or missing second frame.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int WORD_W   = 9;
  localparam int MAX_WORDS = 3;
  localparam int FRAME_W  = WORD_W * MAX_WORDS;
  localparam int BITS_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } spi9_state_e;
endpackage

// File: rtl/spi9_halfclk.sv
module spi9_halfclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi9_framer.sv
module spi9_framer
  import spi9_pkg::*;
(
  input  logic [7:0]         cmd,
  input  logic [1:0]         cnt,
  input  logic [15:0]        param,
  output logic [FRAME_W-1:0] frame,
  output logic [BITS_W-1:0]  nbits
);
  always_comb begin
    unique case (cnt)
      2'd0: begin
        frame = {1'b0, cmd, {(2*WORD_W){1'b0}}};
        nbits = BITS_W'(WORD_W);
      end
      2'd1: begin
        frame = {1'b0, cmd, 1'b1, param[7:0], {WORD_W{1'b0}}};
        nbits = BITS_W'(2 * WORD_W);
      end
      default: begin
        frame = {1'b0, cmd, 1'b1, param[15:8], 1'b1, param[7:0]};
        nbits = BITS_W'(3 * WORD_W);
      end
    endcase
  end
endmodule

// File: rtl/spi9_engine.sv
module spi9_engine
  import spi9_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [BITS_W-1:0]  nbits,
  input  logic               tick,
  output logic               idle,
  output logic               done,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n
);
  spi9_state_e        state;
  logic [FRAME_W-1:0] sh;
  logic [BITS_W-1:0]  left;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sh    <= '0;
      left  <= '0;
      sclk  <= 1'b1;
      mosi  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          sh    <= frame;
          left  <= nbits;
          cs_n  <= 1'b0;
          state <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sclk  <= 1'b0;
          mosi  <= sh[FRAME_W-1];
          sh    <= sh << 1;
          left  <= left - 1'b1;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (left == '0) state <= ST_TRAIL;
          end else begin
            sclk <= 1'b0;
            mosi <= sh[FRAME_W-1];
            sh   <= sh << 1;
            left <= left - 1'b1;
          end
        end
        ST_TRAIL: if (tick) begin
          cs_n  <= 1'b1;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi9_writer.sv
module spi9_writer
  import spi9_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_reg,
  input  logic [1:0]  req_cnt,
  input  logic [15:0] req_param,
  output logic        done,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);
  logic [FRAME_W-1:0] frame;
  logic [BITS_W-1:0]  nbits;
  logic               idle;
  logic               tick;
  logic               start;

  assign req_ready = idle;
  assign busy      = !idle;
  assign start     = req_valid && idle;

  spi9_framer u_framer (
    .cmd   (req_reg),
    .cnt   (req_cnt),
    .param (req_param),
    .frame (frame),
    .nbits (nbits)
  );

  spi9_halfclk #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!idle),
    .tick  (tick)
  );

  spi9_engine u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .frame (frame),
    .nbits (nbits),
    .tick  (tick),
    .idle  (idle),
    .done  (done),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n)
  );
endmodule

// File: rtl/spi9_writer_chk.sv
module spi9_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic cs_n
);
  // R6: clock idles high outside a transaction
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  // R6: data is stable at each sampling edge
  a_r6_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  // R7: select falls while the clock is still idle
  a_r7_cs_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (sclk && $past(sclk)));
  // R7: select rises only with the clock high
  a_r7_cs_trail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk && $past(sclk)));
  // R8: no request taken while select is low
  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (!req_ready && busy));
  // R9: done is a single pulse, coincident with select release
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
endmodule

bind spi9_writer spi9_writer_chk u_chk (.*);

// File: tb/tb_spi9_writer.sv
`timescale 1ns/1ps
module tb_spi9_writer;
  localparam int HALF_DIV = 2;
  localparam int HALF_NS  = HALF_DIV * 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_reg = '0;
  logic [1:0] req_cnt = '0;
  logic [15:0] req_param = '0;
  logic req_ready, done, busy, sclk, mosi, cs_n;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  spi9_writer #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reg(req_reg), .req_cnt(req_cnt), .req_param(req_param),
    .done(done), .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  // bus monitor
  logic [31:0] cap;
  int nbits;
  logic [31:0] frames [0:15];
  int lens [0:15];
  int nfr = 0;
  int ndone = 0;
  longint t_csf, t_ff, t_lr, t_csr;

  always @(negedge cs_n) begin
    cap = '0; nbits = 0; t_csf = $time;
  end
  always @(negedge sclk) if (!cs_n && nbits == 0) t_ff = $time;
  always @(posedge sclk) begin
    if (!cs_n) begin cap = {cap[30:0], mosi}; nbits++; end
    t_lr = $time;
  end
  always @(posedge cs_n) if (rst_n) begin
    t_csr = $time;
    if (nfr < 16) begin frames[nfr] = cap; lens[nfr] = nbits; end
    nfr++;
  end
  always @(posedge clk) if (rst_n && done) ndone++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] c);
    return (c == 2'd0) ? 9 : (c == 2'd1) ? 18 : 27;
  endfunction

  function automatic logic [31:0] exp_frame(input logic [7:0] r, input logic [1:0] c,
                                            input logic [15:0] p);
    if (c == 2'd0) return {23'd0, 1'b0, r};
    if (c == 2'd1) return {14'd0, 1'b0, r, 1'b1, p[7:0]};
    return {5'd0, 1'b0, r, 1'b1, p[15:8], 1'b1, p[7:0]};
  endfunction

  task automatic send_req(input logic [7:0] r, input logic [1:0] c, input logic [15:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_reg = r; req_cnt = c; req_param = p;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && busy, "R8 ready low after accept", {30'd0, req_ready, busy}, 32'h1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input int idx, input logic [7:0] r, input logic [1:0] c,
                             input logic [15:0] p, input string req);
    chk(lens[idx] == exp_len(c), {req, " frame length (R1)"}, lens[idx], exp_len(c));
    chk(frames[idx] == exp_frame(r, c, p), {req, " frame bits (R1)"},
        frames[idx], exp_frame(r, c, p));
  endtask

  task automatic one_xfer(input logic [7:0] r, input logic [1:0] c, input logic [15:0] p,
                          input string req);
    int d0 = ndone;
    int f0 = nfr;
    send_req(r, c, p);
    wait_idle();
    chk(nfr == f0 + 1, {req, " one frame"}, nfr, f0 + 1);
    chk(ndone == d0 + 1, "R9 one done pulse", ndone, d0 + 1);
    check_frame(f0, r, c, p, req);
    chk(t_ff - t_csf >= HALF_NS, "R7 cs lead time", 32'(t_ff - t_csf), HALF_NS);
    chk(t_csr - t_lr >= HALF_NS, "R7 cs trail time", 32'(t_csr - t_lr), HALF_NS);
  endtask

  task automatic test_reset();
    chk(cs_n && sclk && req_ready && !busy && !done, "R10 reset state",
        {27'd0, cs_n, sclk, req_ready, busy, done}, 32'h1C);
  endtask

  task automatic test_counts();
    one_xfer(8'h29, 2'd0, 16'h0000, "R2 command only");
    one_xfer(8'hB0, 2'd1, 16'hA517, "R3 one data byte");
    one_xfer(8'hB8, 2'd2, 16'hFFF9, "R4 two data bytes");
    one_xfer(8'hC3, 2'd3, 16'h2040, "R5 count three as two");
    one_xfer(8'h00, 2'd2, 16'h0180, "R4 flag bits with zero bytes");
  endtask

  task automatic test_backpressure();
    int f0 = nfr;
    int d0 = ndone;
    send_req(8'h3A, 2'd1, 16'h0060);
    send_req(8'hEC, 2'd2, 16'h01F0);  // held while busy
    wait_idle();
    chk(nfr == f0 + 2, "R8 held request not dropped", nfr, f0 + 2);
    chk(ndone == d0 + 2, "R9 done per transaction", ndone, d0 + 2);
    check_frame(f0, 8'h3A, 2'd1, 16'h0060, "R8 first");
    check_frame(f0 + 1, 8'hEC, 2'd2, 16'h01F0, "R8 second");
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_counts();
    test_backpressure();
    test_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule